// File: doc/BRIEF.md
# Scan Chain Segment with Retimed Scan Cells

This block is a segment of a scan chain in which chosen positions use a retimed scan cell instead of the usual multiplexer-in-front-of-flop cell. In a retimed position the flop on the functional path registers the functional input every cycle, a second (shadow) flop registers the serial scan input every cycle, and a multiplexer after the two flops picks one of them. The multiplexer is steered by a copy of scan-enable that was registered at the same edge, so the scan multiplexer leaves the timing path into the flop and sits after it.

A single enable-delay flop serves every retimed position in the segment. Plain positions keep the ordinary cell, and the two kinds can be mixed freely along the chain. Seen from the ports, the segment is cycle-for-cycle the same as a chain built only from plain cells, in functional operation, shifting, launch-off-shift and launch-off-capture test sequences alike. Which positions are retimed is a parameter bit mask.

Top module: `retimed_scan_chain`

## Requirements
- R1: A synchronous active-high reset, applied for at least one rising edge, leaves every bit of `func_out` and `scan_out` at 0 after that edge, whatever `scan_en` was.
- R2: With `scan_en` low at a rising edge, each `func_out[i]` afterwards equals `func_in[i]` as sampled at that edge.
- R3: With `scan_en` high at a rising edge, `func_out[0]` afterwards equals `scan_in` sampled at that edge and each `func_out[i]` for i above 0 equals the `func_out[i-1]` value from before the edge.
- R4: The edge at which `scan_en` changes value already follows the new value: the first shift edge after functional cycles shifts, and the first functional edge after shifting captures, with no extra cycle of latency.
- R5: Positions whose bit is set in `RETIME_MASK` (bit i for position i) are indistinguishable at the ports from plain positions under any sequence of the inputs.
- R6: `scan_out` always equals the last chain position, so a bit entering at `scan_in` appears at `scan_out` after exactly `CHAIN_LEN` consecutive shift edges.
- R7: Launch-off-shift: after a load, a final shift edge followed directly by a functional edge leaves `func_out` equal to the `func_in` seen at that functional edge.
- R8: Launch-off-capture: after a load, two consecutive functional edges leave `func_out` equal to the `func_in` seen at the second of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 selects shifting, 0 selects functional capture |
| scan_in | input | 1 | Serial data into chain position 0 |
| func_in | input | CHAIN_LEN | Functional data, one bit per position |
| func_out | output | CHAIN_LEN | Current value of every chain position |
| scan_out | output | 1 | Serial data from the last position |

## Verification
Every result of this segment falls due one rising edge after the inputs that cause it: a capture, a shift step and a reset all show at the outputs after that single edge, and only the serial unload needs `CHAIN_LEN` edges. The bench applies inputs at the falling edge, advances its reference chain on the next rising edge using exactly those inputs, and compares all outputs at the falling edge that follows, before driving anything new. Enable transitions, launch-off-shift and launch-off-capture sequences are therefore checked at the precise edge where the retimed cell's delayed enable must already agree with the plain cell.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic {
    CELL_PLAIN   = 1'b0,
    CELL_RETIMED = 1'b1
  } cell_kind_e;

  function automatic cell_kind_e kind_of(input logic mask_bit);
    return mask_bit ? CELL_RETIMED : CELL_PLAIN;
  endfunction

endpackage

// File: rtl/rsc_enable_delay.sv
module rsc_enable_delay (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  output logic scan_en_q
);

  always_ff @(posedge clk) begin
    if (rst) scan_en_q <= 1'b0;
    else     scan_en_q <= scan_en;
  end

endmodule

// File: rtl/rsc_plain_cell.sv
module rsc_plain_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_scan,
  input  logic ser_in,
  input  logic fun_in,
  output logic cell_q
);

  always_ff @(posedge clk) begin
    if (rst)           cell_q <= 1'b0;
    else if (sel_scan) cell_q <= ser_in;
    else               cell_q <= fun_in;
  end

endmodule

// File: rtl/rsc_retimed_cell.sv
module rsc_retimed_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel_scan_q,
  input  logic ser_in,
  input  logic fun_in,
  output logic cell_q
);

  logic main_q;
  logic shadow_q;

  // Both flops load unconditionally; the choice is made after them.
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q   <= 1'b0;
      shadow_q <= 1'b0;
    end else begin
      main_q   <= fun_in;
      shadow_q <= ser_in;
    end
  end

  assign cell_q = sel_scan_q ? shadow_q : main_q;

endmodule

// File: rtl/retimed_scan_chain.sv
module retimed_scan_chain #(
  parameter int                   CHAIN_LEN   = 8,
  parameter logic [CHAIN_LEN-1:0] RETIME_MASK = 8'b1010_0110
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_in,
  output logic [CHAIN_LEN-1:0] func_out,
  output logic                 scan_out
);
  import rsc_pkg::*;

  localparam bit ANY_RETIMED = |RETIME_MASK;

  logic [CHAIN_LEN:0] link;
  logic               scan_en_q;

  assign link[0] = scan_in;

  generate
    if (ANY_RETIMED) begin : g_shared_delay
      rsc_enable_delay u_en_dly (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .scan_en_q (scan_en_q)
      );
    end else begin : g_no_delay
      assign scan_en_q = 1'b0;
    end

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_pos
      if (kind_of(RETIME_MASK[i]) == CELL_RETIMED) begin : g_rt
        rsc_retimed_cell u_cell (
          .clk        (clk),
          .rst        (rst),
          .sel_scan_q (scan_en_q),
          .ser_in     (link[i]),
          .fun_in     (func_in[i]),
          .cell_q     (link[i+1])
        );
      end else begin : g_pl
        rsc_plain_cell u_cell (
          .clk      (clk),
          .rst      (rst),
          .sel_scan (scan_en),
          .ser_in   (link[i]),
          .fun_in   (func_in[i]),
          .cell_q   (link[i+1])
        );
      end
    end
  endgenerate

  assign func_out = link[CHAIN_LEN:1];
  assign scan_out = link[CHAIN_LEN];

endmodule

// File: rtl/rsc_chain_chk.sv
module rsc_chain_chk #(
  parameter int CHAIN_LEN = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scan_en,
  input logic                 scan_in,
  input logic [CHAIN_LEN-1:0] func_in,
  input logic [CHAIN_LEN-1:0] func_out,
  input logic                 scan_out
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (func_out == '0) && (scan_out == 1'b0));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> func_out == $past(func_in));

  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> func_out == {$past(func_out[CHAIN_LEN-2:0]), $past(scan_in)});

  a_r4_first_shift: assert property (@(posedge clk) disable iff (rst)
    $rose(scan_en) |=> func_out[0] == $past(scan_in));

  a_r4_first_capture: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |=> func_out == $past(func_in));

endmodule

bind retimed_scan_chain rsc_chain_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (.*);

// File: tb/retimed_scan_chain_tb.sv
module retimed_scan_chain_tb;
  localparam int N = 8;
  localparam logic [N-1:0] MASK = 8'b1010_0110;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scan_en = 1'b0;
  logic         scan_in = 1'b0;
  logic [N-1:0] func_in = '0;
  logic [N-1:0] func_out;
  logic         scan_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;
  logic [N-1:0] model_q = '0;
  logic [N-1:0] shifted_in;

  always #2.5 clk = ~clk;

  retimed_scan_chain #(.CHAIN_LEN(N), .RETIME_MASK(MASK)) u_dut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .func_in(func_in), .func_out(func_out), .scan_out(scan_out)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Drive at falling edge, model advances at rising edge, compare at next falling edge.
  task automatic step(input logic r, input logic se, input logic si,
                      input logic [N-1:0] fi, input string tag);
    rst = r; scan_en = se; scan_in = si; func_in = fi;
    @(posedge clk);
    if (r)       model_q = '0;
    else if (se) model_q = {model_q[N-2:0], si};
    else         model_q = fi;
    @(negedge clk);
    check(tag, func_out, model_q);
    check("R5", func_out & MASK, model_q & MASK);
    check("R6", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model_q[N-1]});
  endtask

  task automatic load(input string tag);
    for (int k = 0; k < N; k++) step(1'b0, 1'b1, 1'($urandom), N'($urandom), tag);
  endtask

  initial begin
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, '1, "R1");
    step(1'b1, 1'b0, 1'b1, '1, "R1");
    for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 1'($urandom), N'($urandom), "R2");
    for (int k = 0; k < 40; k++) step(1'b0, 1'b1, 1'($urandom), N'($urandom), "R3");
    // R6: a known pattern appears at scan_out after N shifts
    shifted_in = 8'b1100_1011;
    for (int k = 0; k < N; k++) step(1'b0, 1'b1, shifted_in[N-1-k], '0, "R6");
    check("R6", func_out, shifted_in);
    for (int k = 0; k < 60; k++) step(1'b0, 1'(k % 2), 1'($urandom), N'($urandom), "R4");
    for (int p = 0; p < 20; p++) begin
      load("R3");
      step(1'b0, 1'b0, 1'($urandom), N'($urandom), "R7");
    end
    for (int p = 0; p < 20; p++) begin
      load("R3");
      step(1'b0, 1'b0, 1'($urandom), N'($urandom), "R8");
      step(1'b0, 1'b0, 1'($urandom), N'($urandom), "R8");
    end
    for (int k = 0; k < 1000; k++) step(1'b0, 1'($urandom), 1'($urandom), N'($urandom), "R5");
    load("R3");
    step(1'b1, 1'b1, 1'b1, '1, "R1");
    step(1'b0, 1'b0, 1'b0, 8'h5A, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule